// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Register Front End

This block is the digital side of a four-channel, 12-bit voltage converter that a host drives over a parallel port. Each channel has two registers. A staging register is written and read by the host. A live register feeds the converter code. The host picks a channel with a two-bit address. A read/write level and an active-low select decide whether the staging register takes the bus or returns its contents. Read data is registered and leaves on a separate output with its own enable, so that the pad-level tristate can sit in the chip's I/O ring.

An active-low transfer strobe moves all four staging registers into the live registers together, and only while the host port is deselected. The strobe is re-timed to the system clock and counts only when it has stayed active for a minimum number of cycles. An active-low clear forces both banks to a preset code, midscale by default, whatever the state of the select. Between transfers the live codes do not change, so the host can stage a new set of values without the outputs moving part way.

All control pins are sampled on the rising clock edge. The transfer strobe and the clear each pass through a two-stage synchronizer before they act. `rst` is a synchronous, active-high reset.

Top module: `qdac_regfront`

## Requirements
- R1: After `rst` every staging and live register holds the clear code, and `bus_oe` is low. With `CLR_MID`=1 the clear code is 0x800, meaning bit 11, the MSB, is set and all other bits are clear. With `CLR_MID`=0 it is 0x000. `dac_codes` carries channel A in bits 11:0, B in 23:12, C in 35:24 and D in 47:36.
- R2: A rising edge with `cs_n`=0 and `rw`=0 writes `bus_din`, MSB in bit 11, into the staging register picked by `addr`: 00 is A, 01 is B, 10 is C and 11 is D.
- R3: A rising edge with `cs_n`=0 and `rw`=1 makes `bus_oe` high after that edge, with `bus_dout` equal to the addressed staging register. After any other edge, `bus_oe` is low and `bus_dout` is zero.
- R4: While `cs_n`=1 at an edge, no staging register is written and no read is started, whatever the levels of `rw`, `addr` and `bus_din`.
- R5: When `load_n` is held low for at least `MIN_LOAD_CYC` sampling edges while `cs_n`=1, all four live registers take the staging values together. The first copy appears `MIN_LOAD_CYC`+1 edges after the first low sample.
- R6: A `load_n` pulse shorter than `MIN_LOAD_CYC` edges leaves the live registers unchanged.
- R7: A `load_n` pulse that occurs while `cs_n`=0 leaves the live registers unchanged.
- R8: Apart from a qualified transfer, a clear or a reset, `dac_codes` holds its value, even while staging registers are written.
- R9: A `load_n`-independent low sample of `clr_n` sets both banks to the clear code two edges later, whether `cs_n` is high or low.
- R10: A clear that lands on the same edge as a write or a transfer wins. The written staging register and the live registers end at the clear code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low host port select |
| rw | input | 1 | 1 = read staging register, 0 = write it |
| addr | input | 2 | Channel select, 00 = A to 11 = D |
| bus_din | input | 12 | Write data from the host bus |
| bus_dout | output | 12 | Registered read data |
| bus_oe | output | 1 | High when `bus_dout` should drive the bus |
| load_n | input | 1 | Active-low transfer strobe, asynchronous |
| clr_n | input | 1 | Active-low clear, asynchronous |
| dac_codes | output | 48 | Four live codes, channel A in the low bits |

## Verification
A wrong staging value is invisible on `dac_codes` until a transfer. It shows on `bus_dout` one edge after a read of that channel, so every write is paired with a readback. A wrong live value or a premature copy shows on `dac_codes` at once. The transfer qualifier is the subtle part: a pulse one edge too short, or a pulse with the port selected, must leave `dac_codes` unchanged for the whole settling window. A wrong clear priority shows only when a read of the written channel follows the collision.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } bus_op_e;

  // host port cycle decode: select gates everything
  function automatic bus_op_e decode_op(input logic sel_n, input logic rd_wr);
    if (sel_n)      return OP_IDLE;
    else if (rd_wr) return OP_READ;
    else            return OP_WRITE;
  endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/qdac_ldq.sv
module qdac_ldq #(
  parameter int MIN_LOAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_low,
  output logic qualified
);
  localparam int CW = $clog2(MIN_LOAD_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOAD_CYC);
  localparam logic [CW-1:0] THR = CW'(MIN_LOAD_CYC - 1);

  logic [CW-1:0] low_cnt_q;

  // counts cycles the synchronized strobe has been low, saturating
  always_ff @(posedge clk) begin
    if (rst || !strobe_low)    low_cnt_q <= '0;
    else if (low_cnt_q != SAT) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign qualified = strobe_low && (low_cnt_q >= THR);
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
#(
  parameter int                DATA_W   = 12,
  parameter int                NCH      = 4,
  parameter int                ADDR_W   = 2,
  parameter logic [DATA_W-1:0] CLR_CODE = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bus_op_e               op,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     din,
  input  logic                  clr,
  input  logic                  load,
  output logic [NCH*DATA_W-1:0] stage_flat,
  output logic [NCH*DATA_W-1:0] live_flat,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_oe
);
  logic [DATA_W-1:0] stage_q [NCH];
  logic [DATA_W-1:0] live_q  [NCH];

  // staging bank: clear beats host write
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NCH; i++) stage_q[i] <= CLR_CODE;
    end else if (op == OP_WRITE) begin
      stage_q[addr] <= din;
    end
  end

  // live bank: clear beats transfer, otherwise hold
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NCH; i++) live_q[i] <= CLR_CODE;
    end else if (load) begin
      for (int i = 0; i < NCH; i++) live_q[i] <= stage_q[i];
    end
  end

  // registered readback
  always_ff @(posedge clk) begin
    if (rst || op != OP_READ) begin
      rd_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_oe   <= 1'b1;
      rd_data <= stage_q[addr];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign stage_flat[g*DATA_W +: DATA_W] = stage_q[g];
    assign live_flat[g*DATA_W +: DATA_W]  = live_q[g];
  end
endmodule

// File: rtl/qdac_regfront.sv
module qdac_regfront
  import qdac_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int NCH          = 4,
  parameter int MIN_LOAD_CYC = 2,
  parameter bit CLR_MID      = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cs_n,
  input  logic                                rw,
  input  logic [$clog2(NCH)-1:0]              addr,
  input  logic [DATA_W-1:0]                   bus_din,
  output logic [DATA_W-1:0]                   bus_dout,
  output logic                                bus_oe,
  input  logic                                load_n,
  input  logic                                clr_n,
  output logic [NCH*DATA_W-1:0]               dac_codes
);
  localparam int ADDR_W = $clog2(NCH);
  localparam logic [DATA_W-1:0] CLR_CODE =
    CLR_MID ? (DATA_W'(1) << (DATA_W - 1)) : '0;

  logic [1:0]            ctl_sync;
  logic                  load_low;
  logic                  load_qual;
  logic                  load_fire;
  logic                  clr_act;
  bus_op_e               op;
  logic [NCH*DATA_W-1:0] stage_flat;

  qdac_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({clr_n, load_n}),
    .sync_out (ctl_sync)
  );

  assign load_low = !ctl_sync[0];
  assign clr_act  = !ctl_sync[1];

  qdac_ldq #(.MIN_LOAD_CYC(MIN_LOAD_CYC)) u_ldq (
    .clk        (clk),
    .rst        (rst),
    .strobe_low (load_low),
    .qualified  (load_qual)
  );

  // transfer only with the host port deselected
  assign load_fire = load_qual && cs_n;
  assign op        = decode_op(cs_n, rw);

  qdac_bank #(
    .DATA_W   (DATA_W),
    .NCH      (NCH),
    .ADDR_W   (ADDR_W),
    .CLR_CODE (CLR_CODE)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .addr       (addr),
    .din        (bus_din),
    .clr        (clr_act),
    .load       (load_fire),
    .stage_flat (stage_flat),
    .live_flat  (dac_codes),
    .rd_data    (bus_dout),
    .rd_oe      (bus_oe)
  );
endmodule

// File: rtl/qdac_regfront_chk.sv
module qdac_regfront_chk #(
  parameter int                DATA_W   = 12,
  parameter int                NCH      = 4,
  parameter logic [DATA_W-1:0] CLR_CODE = '0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cs_n,
  input logic                  rw,
  input logic                  bus_oe,
  input logic [NCH*DATA_W-1:0] dac_codes,
  input logic [NCH*DATA_W-1:0] stage_flat,
  input logic                  load_fire,
  input logic                  clr_act
);
  localparam logic [NCH*DATA_W-1:0] ALL_CLR = {NCH{CLR_CODE}};

  assert_read_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && rw) |=> bus_oe);

  assert_cs_guard_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !clr_act) |=> ($stable(stage_flat) && !bus_oe));

  assert_load_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (load_fire && !clr_act) |=> (dac_codes == $past(stage_flat)));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!load_fire && !clr_act) |=> $stable(dac_codes));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (dac_codes == ALL_CLR));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (stage_flat == ALL_CLR));
endmodule

bind qdac_regfront qdac_regfront_chk #(
  .DATA_W   (DATA_W),
  .NCH      (NCH),
  .CLR_CODE (CLR_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .rw         (rw),
  .bus_oe     (bus_oe),
  .dac_codes  (dac_codes),
  .stage_flat (stage_flat),
  .load_fire  (load_fire),
  .clr_act    (clr_act)
);

// File: tb/test_qdac_regfront.sv
module test_qdac_regfront;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int NC = 4;
  localparam int MINL = 2;
  localparam logic [DW-1:0] MID = 12'h800;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          rw = 1'b1;
  logic [1:0]    addr = '0;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] bus_dout;
  logic          bus_oe;
  logic          load_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [NC*DW-1:0] dac_codes;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] m_in  [NC];
  logic [DW-1:0] m_out [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_regfront #(.DATA_W(DW), .NCH(NC), .MIN_LOAD_CYC(MINL), .CLR_MID(1'b1)) i_qdac_regfront (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .load_n(load_n), .clr_n(clr_n), .dac_codes(dac_codes)
  );

  function automatic logic [NC*DW-1:0] pack_out();
    logic [NC*DW-1:0] v;
    for (int i = 0; i < NC; i++) v[i*DW +: DW] = m_out[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [NC*DW-1:0] act,
                       input logic [NC*DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    check(dac_codes == pack_out(), req, dac_codes, pack_out());
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_write(input int ch, input logic [DW-1:0] v);
    cs_n = 1'b0; rw = 1'b0; addr = 2'(ch); bus_din = v;
    @(posedge clk); @(negedge clk);
    cs_n = 1'b1; rw = 1'b1;
    m_in[ch] = v;
  endtask

  task automatic do_read(input int ch, input string req);
    cs_n = 1'b0; rw = 1'b1; addr = 2'(ch);
    @(posedge clk); @(negedge clk);
    check(bus_oe === 1'b1 && bus_dout === m_in[ch], req,
          {bus_oe, bus_dout}, {1'b1, m_in[ch]});
    cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(bus_oe === 1'b0 && bus_dout === '0, "R3 idle", {bus_oe, bus_dout}, '0);
  endtask

  task automatic do_load(input int len, input bit sel);
    cs_n = !sel; rw = 1'b1;
    load_n = 1'b0;
    repeat (len) @(posedge clk);
    @(negedge clk);
    load_n = 1'b1;
    repeat (MINL + 4) @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1;
    if (len >= MINL && !sel)
      for (int i = 0; i < NC; i++) m_out[i] = m_in[i];
  endtask

  task automatic do_clear();
    clr_n = 1'b0;
    @(posedge clk); @(negedge clk);
    clr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin m_in[i] = MID; m_out[i] = MID; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NC; i++) begin m_in[i] = MID; m_out[i] = MID; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // R1 reset state
    check_out("R1 reset codes");
    check(bus_oe === 1'b0, "R1 oe", {47'd0, bus_oe}, '0);
    for (int i = 0; i < NC; i++) do_read(i, "R1 staging reset");

    // R2 directed writes with readback, outputs untouched (R8)
    do_write(0, 12'hFFF); do_write(1, 12'h001); do_write(2, 12'hA5C); do_write(3, 12'h800);
    check_out("R8 hold during writes");
    for (int i = 0; i < NC; i++) do_read(i, "R2 write/R3 read");

    // R4 write attempt with select high, read attempt with select high
    cs_n = 1'b1; rw = 1'b0; addr = 2'd0; bus_din = 12'h123;
    @(posedge clk); @(negedge clk);
    rw = 1'b1;
    @(posedge clk); @(negedge clk);
    check(bus_oe === 1'b0, "R4 no read", {47'd0, bus_oe}, '0);
    do_read(0, "R4 no write");

    // R6 short transfer pulse
    do_load(1, 1'b0);
    check_out("R6 short pulse");
    // R7 transfer with port selected
    do_load(4, 1'b1);
    check_out("R7 selected");
    // R5 qualified transfer
    do_load(MINL, 1'b0);
    check_out("R5 transfer");
    do_write(2, 12'h3C3);
    check_out("R8 hold after write");

    // R9 clear while selected
    cs_n = 1'b0; rw = 1'b1;
    do_clear();
    check_out("R9 clear selected");
    for (int i = 0; i < NC; i++) do_read(i, "R9 staging cleared");

    // R10 clear on the same edge as a write
    do_write(1, 12'h777);
    clr_n = 1'b0;
    @(posedge clk); @(negedge clk);
    clr_n = 1'b1;
    @(posedge clk); @(negedge clk);
    do_write(1, 12'h0F0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin m_in[i] = MID; m_out[i] = MID; end
    do_read(1, "R10 clear beats write");

    // R10 clear during a held transfer
    do_write(3, 12'h456);
    load_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    do_clear();
    repeat (2) @(posedge clk);
    @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_out("R10 clear beats transfer");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int sel = int'($urandom_range(0, 9));
      int ch = int'($urandom_range(0, 3));
      if (sel < 4) begin
        do_write(ch, 12'($urandom));
        check_out("R8 random hold");
      end else if (sel < 7) begin
        do_read(ch, "R3 random read");
      end else if (sel < 9) begin
        do_load(int'($urandom_range(1, 4)), 1'($urandom_range(0, 3) == 0));
        check_out("R5 random transfer");
      end else if ($urandom_range(0, 3) == 0) begin
        do_clear();
        check_out("R9 random clear");
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule